// File: doc/BRIEF.md
# Paired Event Counters with Overflow Halt

This block holds two wide event counters used for performance measurement. Typical use is to point one counter at a "read hit in cache" strobe and the other at a "data read issued" strobe, so that software can later divide the two values to get a hit rate. Each counter picks its event from a bank of single-cycle strobe inputs. The pick is made by a select field in a control register. Counting runs only while a global enable bit is set.

The counters are wider than the 32-bit register data path, so each is reached through a low word and a high word. A read of the low word captures the upper bits of the same counter. A later read of the high word then returns a value that matches the low word already read. If either counter is full and is asked to count again, it does not wrap. At that point both counters freeze and a sticky interrupt flag is raised, which keeps the pair valid as a ratio. The interrupt handler reads both counters and rewrites or clears them. It then writes 1 to the status bit, which releases the freeze.

Register reads are registered: the data appears on the read-data port one clock after the read strobe. Read-data holds its value until the next read.

Top module: `evt_pair_counter`

## Requirements
- R1: After reset both counters read zero, the control word reads zero (counting disabled) and the interrupt output is low.
- R2: A counter adds exactly one at each rising edge where its selected strobe is high, the enable bit is set and the interrupt flag is clear. No other case increments it.
- R3: The control word is at address 0. Bit 0 is the global enable. The event select of counter k is the 3-bit field starting at bit 4+4k: counter 0 uses bits 6:4 and counter 1 uses bits 10:8. The control word reads back as written.
- R4: Counter k has its low word at address 2+2k and its high word at address 3+2k. A high-word write loads counter bits 39:32 from write-data bits 7:0. A read returns its data one clock after the read strobe, and the data holds until the next read.
- R5: A read of a counter's low word captures that counter's bits 39:32. A later read of the high word returns the captured bits, even if the counter has changed in between.
- R6: If a register write hits a counter in the same cycle as an increment request for it, the written value is stored and the increment is dropped.
- R7: A counter holding all ones that receives an increment request stays at all ones. On the next edge the interrupt flag is set.
- R8: While the interrupt flag is set, neither counter changes except through register writes.
- R9: The interrupt flag is sticky. Writing 1 to bit 0 of the status word (address 1) clears it, and writing 0 leaves it set. Once the flag is clear and the enable bit is set, counting resumes.
- R10: With the enable bit clear, strobes do not change either counter, and the interrupt flag stays low.
- R11: Bit 0 of the status word reads as the current interrupt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_strobe | input | NUM_EVT (8) | Single-cycle event strobes |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (4) | Register word address |
| reg_wdata | input | DATA_W (32) | Register write data |
| reg_rdata | output | DATA_W (32) | Registered read data |
| irq | output | 1 | Sticky overflow interrupt |

## Verification
The bench drives each counter to within a few counts of all ones and holds the strobe high. This checks that the full counter saturates rather than wrapping to zero, and that the other counter, which was still counting, freezes on the same edge that the flag rises; a design that halted only the overflowing counter would let the ratio drift. It changes the upper bits between a low-word read and a high-word read, so a design that forgot to capture those bits would return the new upper bits. It also writes a counter while its strobe is active, which catches a design that lets the increment win. Finally it writes 0 and then 1 to the status bit: a design that cleared the flag on any write would drop the interrupt too early, and one that never re-armed counting would leave the counters frozen.

// File: rtl/epc_pkg.sv
package epc_pkg;
   // register word addresses
   localparam int REG_CTRL     = 0;
   localparam int REG_STATUS   = 1;
   localparam int REG_CNT_BASE = 2;
   // control word layout
   localparam int CTRL_EN_BIT     = 0;
   localparam int CTRL_SEL_LSB    = 4;
   localparam int CTRL_SEL_STRIDE = 4;
   // status word layout
   localparam int STAT_IRQ_BIT = 0;

   function automatic int cnt_lo_addr(input int idx);
      return REG_CNT_BASE + 2 * idx;
   endfunction

   function automatic int cnt_hi_addr(input int idx);
      return REG_CNT_BASE + 2 * idx + 1;
   endfunction
endpackage

// File: rtl/epc_counter.sv
module epc_counter #(
   parameter int CNT_W   = 40,
   parameter int DATA_W  = 32,
   parameter int NUM_EVT = 8,
   parameter int SEL_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [NUM_EVT-1:0] evt,
   input  logic [SEL_W-1:0]   sel,
   input  logic               wr_lo,
   input  logic               wr_hi,
   input  logic [DATA_W-1:0]  wdata,
   output logic [CNT_W-1:0]   cnt,
   output logic               ovf
);
   localparam int HI_W = CNT_W - DATA_W;

   logic evt_hit;
   logic inc_req;
   logic full;
   logic wr_any;

   generate
      if (NUM_EVT == (1 << SEL_W)) begin : g_pow2
         assign evt_hit = evt[sel];
      end else begin : g_guard
         assign evt_hit = (int'(sel) < NUM_EVT) ? evt[sel] : 1'b0;
      end
   endgenerate

   assign inc_req = run & evt_hit;
   assign full    = &cnt;
   assign wr_any  = wr_lo | wr_hi;
   assign ovf     = inc_req & full & ~wr_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (wr_any) begin
         if (wr_lo) cnt[DATA_W-1:0]     <= wdata;
         if (wr_hi) cnt[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
      end else if (inc_req && !full) begin
         cnt <= cnt + 1'b1;
      end
   end

   // R2
   step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_any |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1));

   // R8
   frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_any) |=> $stable(cnt));

   // R7
   saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !wr_any) |=> &cnt);
endmodule

// File: rtl/epc_regs.sv
module epc_regs
   import epc_pkg::*;
#(
   parameter int CNT_W   = 40,
   parameter int DATA_W  = 32,
   parameter int NUM_CNT = 2,
   parameter int SEL_W   = 3,
   parameter int ADDR_W  = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic                     rd_en,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [NUM_CNT*CNT_W-1:0] cnt_flat,
   input  logic [NUM_CNT-1:0]       ovf_vec,
   output logic                     enable,
   output logic [NUM_CNT*SEL_W-1:0] sel_flat,
   output logic [NUM_CNT-1:0]       wr_lo_vec,
   output logic [NUM_CNT-1:0]       wr_hi_vec,
   output logic [DATA_W-1:0]        rdata,
   output logic                     irq
);
   localparam int HI_W = CNT_W - DATA_W;

   logic              enable_q;
   logic [SEL_W-1:0]  sel_q [NUM_CNT];
   logic              irq_q;
   logic [HI_W-1:0]   hi_q  [NUM_CNT];
   logic [DATA_W-1:0] rdata_q;
   logic [DATA_W-1:0] rd_mux;
   logic              ctrl_wr;
   logic              clr_req;
   logic              unused_wdata;

   assign ctrl_wr      = wr_en && (addr == ADDR_W'(REG_CTRL));
   assign clr_req      = wr_en && (addr == ADDR_W'(REG_STATUS)) && wdata[STAT_IRQ_BIT];
   assign unused_wdata = ^wdata;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CNT; gi++) begin : g_dec
         assign wr_lo_vec[gi] = wr_en && (addr == ADDR_W'(cnt_lo_addr(gi)));
         assign wr_hi_vec[gi] = wr_en && (addr == ADDR_W'(cnt_hi_addr(gi)));
         assign sel_flat[gi*SEL_W +: SEL_W] = sel_q[gi];
      end
   endgenerate

   always_comb begin
      rd_mux = '0;
      if (addr == ADDR_W'(REG_CTRL)) begin
         rd_mux[CTRL_EN_BIT] = enable_q;
         for (int i = 0; i < NUM_CNT; i++)
            rd_mux[CTRL_SEL_LSB + CTRL_SEL_STRIDE*i +: SEL_W] = sel_q[i];
      end else if (addr == ADDR_W'(REG_STATUS)) begin
         rd_mux[STAT_IRQ_BIT] = irq_q;
      end
      for (int i = 0; i < NUM_CNT; i++) begin
         if (addr == ADDR_W'(cnt_lo_addr(i))) rd_mux = cnt_flat[i*CNT_W +: DATA_W];
         if (addr == ADDR_W'(cnt_hi_addr(i))) rd_mux = DATA_W'(hi_q[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q <= 1'b0;
         for (int i = 0; i < NUM_CNT; i++) sel_q[i] <= '0;
      end else if (ctrl_wr) begin
         enable_q <= wdata[CTRL_EN_BIT];
         for (int i = 0; i < NUM_CNT; i++)
            sel_q[i] <= wdata[CTRL_SEL_LSB + CTRL_SEL_STRIDE*i +: SEL_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else if (|ovf_vec) begin
         irq_q <= 1'b1;
      end else if (clr_req) begin
         irq_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         for (int i = 0; i < NUM_CNT; i++) hi_q[i] <= '0;
      end else if (rd_en) begin
         rdata_q <= rd_mux;
         for (int i = 0; i < NUM_CNT; i++)
            if (addr == ADDR_W'(cnt_lo_addr(i)))
               hi_q[i] <= cnt_flat[i*CNT_W + DATA_W +: HI_W];
      end
   end

   assign enable = enable_q;
   assign irq    = irq_q;
   assign rdata  = rdata_q;

   // R7
   ovf_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|ovf_vec) |=> irq_q);

   // R9
   irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !clr_req) |=> irq_q);

   // R4
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata_q));
endmodule

// File: rtl/evt_pair_counter.sv
module evt_pair_counter
   import epc_pkg::*;
#(
   parameter int CNT_W   = 40,
   parameter int DATA_W  = 32,
   parameter int NUM_EVT = 8,
   parameter int NUM_CNT = 2,
   parameter int ADDR_W  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_strobe,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic               irq
);
   localparam int SEL_W    = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
   localparam int NUM_REGS = REG_CNT_BASE + 2 * NUM_CNT;

   generate
      if (CNT_W <= DATA_W || CNT_W > 2 * DATA_W) begin : g_bad_width
         $error("CNT_W must lie in (DATA_W, 2*DATA_W]");
      end
      if (SEL_W > CTRL_SEL_STRIDE) begin : g_bad_sel
         $error("event select wider than its control field");
      end
      if (CTRL_SEL_LSB + CTRL_SEL_STRIDE * NUM_CNT > DATA_W) begin : g_bad_cnt
         $error("too many counters for the control word");
      end
      if ((1 << ADDR_W) < NUM_REGS) begin : g_bad_addr
         $error("ADDR_W too small for the register map");
      end
   endgenerate

   logic                     enable;
   logic                     irq_i;
   logic                     run;
   logic [NUM_CNT*SEL_W-1:0] sel_flat;
   logic [NUM_CNT-1:0]       wr_lo_vec;
   logic [NUM_CNT-1:0]       wr_hi_vec;
   logic [NUM_CNT-1:0]       ovf_vec;
   logic [NUM_CNT*CNT_W-1:0] cnt_flat;

   assign run = enable & ~irq_i;

   epc_regs #(
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W),
      .NUM_CNT(NUM_CNT),
      .SEL_W  (SEL_W),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr),
      .rd_en    (reg_rd),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .cnt_flat (cnt_flat),
      .ovf_vec  (ovf_vec),
      .enable   (enable),
      .sel_flat (sel_flat),
      .wr_lo_vec(wr_lo_vec),
      .wr_hi_vec(wr_hi_vec),
      .rdata    (reg_rdata),
      .irq      (irq_i)
   );

   genvar gc;
   generate
      for (gc = 0; gc < NUM_CNT; gc++) begin : g_cnt
         epc_counter #(
            .CNT_W  (CNT_W),
            .DATA_W (DATA_W),
            .NUM_EVT(NUM_EVT),
            .SEL_W  (SEL_W)
         ) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .run  (run),
            .evt  (evt_strobe),
            .sel  (sel_flat[gc*SEL_W +: SEL_W]),
            .wr_lo(wr_lo_vec[gc]),
            .wr_hi(wr_hi_vec[gc]),
            .wdata(reg_wdata),
            .cnt  (cnt_flat[gc*CNT_W +: CNT_W]),
            .ovf  (ovf_vec[gc])
         );
      end
   endgenerate

   assign irq = irq_i;

   // R8
   pair_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_i && !reg_wr) |=> $stable(cnt_flat));

   // R10
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !irq_i) |=> !irq_i);
endmodule

// File: tb/evt_pair_counter_tb.sv
`timescale 1ns/1ps
module evt_pair_counter_tb;
   localparam int CW = 40;
   localparam int DW = 32;
   localparam int NC = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  evt = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   always #2.5 clk = ~clk;

   evt_pair_counter u_dut (
      .clk(clk), .rst_n(rst_n), .evt_strobe(evt), .reg_wr(wr_en), .reg_rd(rd_en),
      .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq)
   );

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";
   bit    cmp_on = 0;
   bit    done = 0;

   // behavioural reference model
   logic [CW-1:0]    m_cnt [NC];
   logic [CW-DW-1:0] m_hi  [NC];
   logic [2:0]       m_sel [NC];
   logic             m_en, m_irq;
   logic [31:0]      m_rdata;

   always @(posedge clk) begin : model
      logic run, ovf;
      if (!rst_n) begin
         for (int i = 0; i < NC; i++) begin
            m_cnt[i] = '0; m_hi[i] = '0; m_sel[i] = '0;
         end
         m_en = 0; m_irq = 0; m_rdata = '0;
      end else begin
         run = m_en && !m_irq;
         ovf = 0;
         if (rd_en) begin
            m_rdata = '0;
            if (addr == 0) begin
               m_rdata[0] = m_en; m_rdata[6:4] = m_sel[0]; m_rdata[10:8] = m_sel[1];
            end else if (addr == 1) m_rdata[0] = m_irq;
            for (int i = 0; i < NC; i++) begin
               if (int'(addr) == 2 + 2*i) begin
                  m_rdata = m_cnt[i][DW-1:0];
                  m_hi[i] = m_cnt[i][CW-1:DW];
               end
               if (int'(addr) == 3 + 2*i) m_rdata = 32'(m_hi[i]);
            end
         end
         for (int i = 0; i < NC; i++) begin
            if (wr_en && int'(addr) == 2 + 2*i) m_cnt[i][DW-1:0] = wdata;
            else if (wr_en && int'(addr) == 3 + 2*i) m_cnt[i][CW-1:DW] = wdata[CW-DW-1:0];
            else if (run && evt[m_sel[i]]) begin
               if (&m_cnt[i]) ovf = 1;
               else m_cnt[i] = m_cnt[i] + 1;
            end
         end
         if (wr_en && addr == 0) begin
            m_en = wdata[0]; m_sel[0] = wdata[6:4]; m_sel[1] = wdata[10:8];
         end
         if (ovf) m_irq = 1;
         else if (wr_en && addr == 1 && wdata[0]) m_irq = 0;
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (cmp_on && rst_n && !done) begin
         chk({cur_req, " irq vs model"}, 64'(irq), 64'(m_irq));
         chk({cur_req, " rdata vs model"}, 64'(rdata), 64'(m_rdata));
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1; addr = a;
      @(negedge clk);
      rd_en = 0;
      d = rdata;
   endtask

   task automatic finish_run();
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      int c0, c1;
      repeat (3) @(negedge clk);
      rst_n = 1;
      cmp_on = 1;

      // R1: reset state
      cur_req = "R1";
      chk("R1 irq after reset", 64'(irq), 0);
      rd(0, v); chk("R1 ctrl after reset", 64'(v), 0);
      rd(2, v); chk("R1 cnt0 lo after reset", 64'(v), 0);
      rd(5, v); chk("R1 cnt1 hi after reset", 64'(v), 0);

      // R3: control layout, en=1, sel0=2, sel1=5
      cur_req = "R3";
      wr(0, 32'h0000_0521);
      rd(0, v); chk("R3 ctrl readback", 64'(v), 64'h521);

      // R2: random strobes
      cur_req = "R2";
      c0 = 0; c1 = 0;
      for (int k = 0; k < 60; k++) begin
         @(negedge clk);
         evt = 8'($urandom);
         c0 += int'(evt[2]); c1 += int'(evt[5]);
      end
      @(negedge clk); evt = 0;
      wr(0, 32'h0000_0520);
      rd(2, v); chk("R2 cnt0 count", 64'(v), 64'(c0));
      rd(4, v); chk("R2 cnt1 count", 64'(v), 64'(c1));

      // R10: disabled, strobes ignored
      cur_req = "R10";
      @(negedge clk); evt = 8'hFF;
      repeat (10) @(negedge clk);
      evt = 0;
      rd(2, v); chk("R10 cnt0 unchanged when disabled", 64'(v), 64'(c0));
      rd(4, v); chk("R10 cnt1 unchanged when disabled", 64'(v), 64'(c1));
      chk("R10 irq low when disabled", 64'(irq), 0);

      // R4 / R5: word access and coherent high capture
      cur_req = "R5";
      wr(3, 32'h12);
      wr(2, 32'hFFFF_FFFF);
      rd(2, v); chk("R4 cnt0 lo write/read", 64'(v), 64'hFFFF_FFFF);
      wr(0, 32'h0000_0521);
      evt = 8'h04;
      @(negedge clk); evt = 0;
      wr(0, 32'h0000_0520);
      rd(3, v); chk("R5 captured high before carry", 64'(v), 64'h12);
      rd(2, v); chk("R5 low after carry", 64'(v), 0);
      rd(3, v); chk("R5 captured high after carry", 64'(v), 64'h13);

      // R6: write beats increment
      cur_req = "R6";
      wr(0, 32'h0000_0521);
      @(negedge clk);
      wr_en = 1; addr = 2; wdata = 32'h55; evt = 8'h04;
      @(negedge clk);
      wr_en = 0; evt = 0;
      wr(0, 32'h0000_0520);
      rd(2, v); chk("R6 write wins over increment", 64'(v), 64'h55);

      // R7 / R8: overflow saturates, pair freezes
      cur_req = "R7";
      wr(3, 32'hFF);
      wr(2, 32'hFFFF_FFFD);
      wr(4, 0);
      wr(5, 0);
      wr(0, 32'h0000_0221);
      evt = 8'h04;
      repeat (6) @(negedge clk);
      evt = 0;
      chk("R7 irq raised on overflow", 64'(irq), 1);
      rd(2, v); chk("R7 cnt0 lo saturated", 64'(v), 64'hFFFF_FFFF);
      rd(3, v); chk("R7 cnt0 hi saturated", 64'(v), 64'hFF);
      cur_req = "R8";
      rd(4, v); chk("R8 cnt1 froze with cnt0", 64'(v), 3);
      rd(1, v); chk("R11 status shows irq", 64'(v), 1);

      // R9: sticky flag, write-one clear, resume
      cur_req = "R9";
      wr(1, 0);
      chk("R9 write 0 keeps irq", 64'(irq), 1);
      wr(0, 32'h0000_0521);
      wr(1, 1);
      chk("R9 write 1 clears irq", 64'(irq), 0);
      evt = 8'h20;
      repeat (4) @(negedge clk);
      evt = 0;
      rd(4, v); chk("R9 counting resumed", 64'(v), 7);
      cur_req = "R11";
      rd(1, v); chk("R11 status clear", 64'(v), 0);

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule